// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Flag and Vector Unit

This block gathers the interrupt conditions of two serial channels, called A and B. Each channel can raise or clear a receive interrupt and a transmit interrupt, and it has a break status bit. From these the block keeps three things: a pending-flag register, a modified interrupt vector, and one combined interrupt request line. The register bus, the data path and the break detection all sit outside the block. They reach it as one-cycle strobes and as level inputs that copy the enable fields of the control registers.

Each channel has an under-service marker for receive and one for transmit. When one interrupt type of a channel is under service, a raise of the other type in that channel still sets its pending flag, but it does not change the vector and it is not marked as under service. A channel command written on the command bus can clear the transmit interrupt. Another command code resets the interrupt that has the highest priority among those under service. The vector can be placed in one of two encodings, low-bit or high-bit, chosen by the status-high control input. The encoding is fixed at the moment the vector is written.

Top module: `dual_irq_vector`

## Requirements
- R1: After rst_n is asserted, irq is 0, pend_reg is 0x00 and vector is 0x00.
- R2: A raise strobe sets its pending bit at the next clock edge, even when the vector is not updated. The pending bits are: receive A 0x20, transmit A 0x10, receive B 0x04, transmit B 0x02. Bits 7, 6, 3 and 0 always read 0.
- R3: A raise that is accepted writes a vector that depends on status_hi. With status_hi high: receive A 0x30, transmit A 0x10, receive B 0x20. With status_hi low: receive A 0x0C, transmit A 0x08, receive B 0x04. Transmit B writes 0x00 in both encodings.
- R4: A receive raise is accepted only while the transmit interrupt of the same channel is not under service. Acceptance marks receive as under service. A transmit raise follows the same rule with the two types swapped. A raise that is refused leaves the vector unchanged.
- R5: A clear drops the pending bit and the under-service marker of that interrupt and writes the no-interrupt vector: 0x60 with status_hi high, 0x06 with it low. A receive clear comes from rx_clear. A transmit clear comes from a cmd_wr write whose cmd_code bits 5:3 equal 101 (for example 0x28).
- R6: A cmd_wr write whose cmd_code bits 5:3 equal 111 (for example 0x38) acts as follows. If receive is under service, it clears receive. Otherwise, if transmit is under service, it clears transmit. Otherwise it does nothing.
- R7: irq is high while, in either channel, any of these holds: tx_ien is set and transmit is pending; the receive mode is 01 or 10 and receive is pending. irq follows the enable inputs in the same cycle they change.
- R8: irq is also high while brk_ien and brk_status are both set in either channel. This does not depend on any pending bit.
- R9: chan_rst clears the pending bits and under-service markers of its own channel only. It ignores that channel's other strobes in the same cycle. It leaves the vector unchanged.
- R10: When several vector writes fall in the same cycle, the first one in this list wins: accepted receive A raise, accepted transmit A raise, accepted receive B raise, accepted transmit B raise, any clear. Within one interrupt, a raise wins over a clear in the same cycle.
- R11: A cmd_wr write with any other code in bits 5:3 (for example 0x10) changes no pending bit, no marker and not the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_rst | input | 2 | Per-channel reset strobe (bit 0 = A, bit 1 = B) |
| rx_raise | input | 2 | Receive interrupt raise strobe per channel |
| rx_clear | input | 2 | Receive interrupt clear strobe per channel |
| tx_raise | input | 2 | Transmit interrupt raise strobe per channel |
| cmd_wr | input | 2 | Command write strobe per channel |
| cmd_code | input | 8 | Command byte; bits 5:3 hold the command field |
| tx_ien | input | 2 | Transmit interrupt enable per channel |
| rx_mode_a | input | 2 | Receive interrupt mode of channel A |
| rx_mode_b | input | 2 | Receive interrupt mode of channel B |
| brk_ien | input | 2 | Break interrupt enable per channel |
| brk_status | input | 2 | Break status per channel |
| status_hi | input | 1 | Selects the high-bit vector encoding |
| irq | output | 1 | Combined interrupt request |
| pend_reg | output | 8 | Pending-flag register |
| vector | output | 8 | Modified interrupt vector |

## Verification
The hardest state to reach is a channel with one interrupt type under service while the other type is raised and refused. The stimulus gets there by raising one type, then the other, and then using the reset-highest command twice. The first command clears the type under service. The second finds the refused type pending but not under service, so it must leave that type alone. The same-cycle priority is reached by driving raises and a clear together across both channels. The reference model in the bench follows every cycle.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

   localparam logic [2:0] CMD_TXCLR  = 3'b101;
   localparam logic [2:0] CMD_IUSRST = 3'b111;

   typedef struct packed {
      logic rx_set;
      logic tx_set;
      logic clr;
   } vec_evt_t;

   typedef enum logic [1:0] {
      SRC_RX   = 2'd0,
      SRC_TX   = 2'd1,
      SRC_NONE = 2'd2
   } vec_src_e;

   function automatic logic [7:0] vec_code(input logic hi, input logic is_b,
                                           input vec_src_e src);
      logic [7:0] c;
      unique case (src)
         SRC_NONE: c = hi ? 8'h60 : 8'h06;
         SRC_RX:   c = is_b ? (hi ? 8'h20 : 8'h04) : (hi ? 8'h30 : 8'h0C);
         default:  c = is_b ? 8'h00 : (hi ? 8'h10 : 8'h08);
      endcase
      return c;
   endfunction

endpackage

// File: rtl/irqv_chan_state.sv
module irqv_chan_state
   import irqv_pkg::*;
#(
   parameter int CMD_LSB = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       chan_rst,
   input  logic       rx_raise,
   input  logic       rx_clear,
   input  logic       tx_raise,
   input  logic       cmd_wr,
   input  logic [7:0] cmd_code,
   input  logic       tx_ien,
   input  logic [1:0] rx_mode,
   input  logic       brk_ien,
   input  logic       brk_status,
   output logic       rx_pend,
   output logic       tx_pend,
   output logic       rx_ius,
   output logic       tx_ius,
   output vec_evt_t   evt,
   output logic       irq_req
);
   localparam int CMD_MSB = CMD_LSB + 2;

   logic [2:0] fld;
   logic       cmd_txclr, cmd_iusrst;
   logic       rx_take, tx_take, rx_clr, tx_clr, rx_ok;

   always_comb begin
      fld        = cmd_code[CMD_MSB:CMD_LSB];
      cmd_txclr  = cmd_wr && (fld == CMD_TXCLR);
      cmd_iusrst = cmd_wr && (fld == CMD_IUSRST);
      rx_take    = rx_raise && !tx_ius;
      tx_take    = tx_raise && !rx_ius;
      rx_clr     = rx_clear || (cmd_iusrst && rx_ius);
      tx_clr     = cmd_txclr || (cmd_iusrst && !rx_ius && tx_ius);
      evt.rx_set = rx_take && !chan_rst;
      evt.tx_set = tx_take && !chan_rst;
      evt.clr    = (rx_clr || tx_clr) && !chan_rst;
      rx_ok      = (rx_mode == 2'b01) || (rx_mode == 2'b10);
      irq_req    = (tx_ien && tx_pend) || (rx_ok && rx_pend) ||
                   (brk_ien && brk_status);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_pend <= 1'b0;
         tx_pend <= 1'b0;
         rx_ius  <= 1'b0;
         tx_ius  <= 1'b0;
      end else if (chan_rst) begin
         rx_pend <= 1'b0;
         tx_pend <= 1'b0;
         rx_ius  <= 1'b0;
         tx_ius  <= 1'b0;
      end else begin
         if (rx_raise)     rx_pend <= 1'b1;
         else if (rx_clr)  rx_pend <= 1'b0;
         if (rx_take)      rx_ius  <= 1'b1;
         else if (rx_clr)  rx_ius  <= 1'b0;
         if (tx_raise)     tx_pend <= 1'b1;
         else if (tx_clr)  tx_pend <= 1'b0;
         if (tx_take)      tx_ius  <= 1'b1;
         else if (tx_clr)  tx_ius  <= 1'b0;
      end
   end

endmodule

// File: rtl/irqv_vec_reg.sv
module irqv_vec_reg
   import irqv_pkg::*;
#(
   parameter logic [7:0] RST_VEC = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       status_hi,
   input  vec_evt_t   evt_a,
   input  vec_evt_t   evt_b,
   output logic [7:0] vector
);
   logic [7:0] nxt;

   always_comb begin
      nxt = vector;
      if (evt_a.rx_set)               nxt = vec_code(status_hi, 1'b0, SRC_RX);
      else if (evt_a.tx_set)          nxt = vec_code(status_hi, 1'b0, SRC_TX);
      else if (evt_b.rx_set)          nxt = vec_code(status_hi, 1'b1, SRC_RX);
      else if (evt_b.tx_set)          nxt = vec_code(status_hi, 1'b1, SRC_TX);
      else if (evt_a.clr || evt_b.clr) nxt = vec_code(status_hi, 1'b0, SRC_NONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vector <= RST_VEC;
      else        vector <= nxt;
   end

endmodule

// File: rtl/dual_irq_vector.sv
module dual_irq_vector
   import irqv_pkg::*;
#(
   parameter int         CH_CNT  = 2,
   parameter int         CMD_LSB = 3,
   parameter logic [7:0] RST_VEC = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] chan_rst,
   input  logic [1:0] rx_raise,
   input  logic [1:0] rx_clear,
   input  logic [1:0] tx_raise,
   input  logic [1:0] cmd_wr,
   input  logic [7:0] cmd_code,
   input  logic [1:0] tx_ien,
   input  logic [1:0] rx_mode_a,
   input  logic [1:0] rx_mode_b,
   input  logic [1:0] brk_ien,
   input  logic [1:0] brk_status,
   input  logic       status_hi,
   output logic       irq,
   output logic [7:0] pend_reg,
   output logic [7:0] vector
);
   generate
      if (CH_CNT != 2) begin : g_bad_cnt
         $error("dual_irq_vector: vector encoding needs exactly two channels");
      end
      if (CMD_LSB < 0 || CMD_LSB > 5) begin : g_bad_cmd
         $error("dual_irq_vector: command field must fit in the command byte");
      end
   endgenerate

   logic [1:0] rx_mode_arr [CH_CNT];
   vec_evt_t   evt         [CH_CNT];
   logic [CH_CNT-1:0] rx_pend, tx_pend, rx_ius, tx_ius, irq_req;

   assign rx_mode_arr[0] = rx_mode_a;
   assign rx_mode_arr[1] = rx_mode_b;

   for (genvar g = 0; g < CH_CNT; g++) begin : g_ch
      irqv_chan_state #(.CMD_LSB(CMD_LSB)) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .chan_rst   (chan_rst[g]),
         .rx_raise   (rx_raise[g]),
         .rx_clear   (rx_clear[g]),
         .tx_raise   (tx_raise[g]),
         .cmd_wr     (cmd_wr[g]),
         .cmd_code   (cmd_code),
         .tx_ien     (tx_ien[g]),
         .rx_mode    (rx_mode_arr[g]),
         .brk_ien    (brk_ien[g]),
         .brk_status (brk_status[g]),
         .rx_pend    (rx_pend[g]),
         .tx_pend    (tx_pend[g]),
         .rx_ius     (rx_ius[g]),
         .tx_ius     (tx_ius[g]),
         .evt        (evt[g]),
         .irq_req    (irq_req[g])
      );
   end

   irqv_vec_reg #(.RST_VEC(RST_VEC)) u_vec (
      .clk       (clk),
      .rst_n     (rst_n),
      .status_hi (status_hi),
      .evt_a     (evt[0]),
      .evt_b     (evt[1]),
      .vector    (vector)
   );

   assign irq      = |irq_req;
   assign pend_reg = {2'b00, rx_pend[0], tx_pend[0], 1'b0, rx_pend[1], tx_pend[1], 1'b0};

endmodule

// File: rtl/irqv_chk.sv
module irqv_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] chan_rst,
   input logic [1:0] rx_raise,
   input logic [1:0] rx_clear,
   input logic [1:0] tx_raise,
   input logic [1:0] cmd_wr,
   input logic [7:0] cmd_code,
   input logic [1:0] brk_ien,
   input logic [1:0] brk_status,
   input logic       status_hi,
   input logic       irq,
   input logic [7:0] pend_reg,
   input logic [7:0] vector,
   input logic [1:0] rx_ius,
   input logic [1:0] tx_ius
);
   AST_RAISE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_raise[0] && !chan_rst[0]) |=> pend_reg[5]); // R2

   AST_REFUSED_NOT_IUS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ius[0] && !rx_ius[0] && rx_raise[0] && !chan_rst[0]) |=> !rx_ius[0]); // R4

   AST_CLEAR_NOINT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_clear[0] && !chan_rst[0] && rx_raise == 2'b00 && tx_raise == 2'b00)
      |=> (vector == ($past(status_hi) ? 8'h60 : 8'h06))); // R5

   AST_IUSRST_RX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr[0] && cmd_code[5:3] == 3'b111 && rx_ius[0] && !rx_raise[0] && !chan_rst[0])
      |=> !pend_reg[5]); // R6

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_reg == 8'h00 && (brk_ien & brk_status) == 2'b00) |-> !irq); // R7

   AST_BRK_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ((brk_ien & brk_status) != 2'b00) |-> irq); // R8

   AST_CHRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      chan_rst[1] |=> (pend_reg[2:1] == 2'b00 && !rx_ius[1] && !tx_ius[1])); // R9

endmodule

bind dual_irq_vector irqv_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chan_rst   (chan_rst),
   .rx_raise   (rx_raise),
   .rx_clear   (rx_clear),
   .tx_raise   (tx_raise),
   .cmd_wr     (cmd_wr),
   .cmd_code   (cmd_code),
   .brk_ien    (brk_ien),
   .brk_status (brk_status),
   .status_hi  (status_hi),
   .irq        (irq),
   .pend_reg   (pend_reg),
   .vector     (vector),
   .rx_ius     (rx_ius),
   .tx_ius     (tx_ius)
);

// File: tb/dual_irq_vector_tb.sv
`timescale 1ns/1ps
module dual_irq_vector_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] chan_rst, rx_raise, rx_clear, tx_raise, cmd_wr;
   logic [7:0] cmd_code;
   logic [1:0] tx_ien, rx_mode_a, rx_mode_b, brk_ien, brk_status;
   logic       status_hi;
   logic       irq;
   logic [7:0] pend_reg, vector;

   always #2.5 clk = ~clk;

   dual_irq_vector u_dut (
      .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .rx_raise(rx_raise),
      .rx_clear(rx_clear), .tx_raise(tx_raise), .cmd_wr(cmd_wr),
      .cmd_code(cmd_code), .tx_ien(tx_ien), .rx_mode_a(rx_mode_a),
      .rx_mode_b(rx_mode_b), .brk_ien(brk_ien), .brk_status(brk_status),
      .status_hi(status_hi), .irq(irq), .pend_reg(pend_reg), .vector(vector)
   );

   int    checks = 0, fails = 0;
   bit    started = 0, done = 0;
   string cur_tag = "R1";

   // behavioural reference state, index 0 = channel A
   int m_rp[2], m_tp[2], m_rs[2], m_ts[2];
   int m_vec;

   function automatic int code_of(int hi, int ch, int kind); // kind 0 rx,1 tx,2 none
      if (kind == 2) return hi ? 'h60 : 'h06;
      if (ch == 1) return (kind == 0) ? (hi ? 'h20 : 'h04) : 'h00;
      return (kind == 0) ? (hi ? 'h30 : 'h0C) : (hi ? 'h10 : 'h08);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            m_rp[c] = 0; m_tp[c] = 0; m_rs[c] = 0; m_ts[c] = 0;
         end
         m_vec = 0;
      end else begin
         int nv, any_clr, win;
         int rset[2], tset[2], rclr[2], tclr[2];
         nv = m_vec; any_clr = 0; win = 0;
         for (int c = 0; c < 2; c++) begin
            int f, txc, ir;
            f   = (cmd_code >> 3) & 7;
            txc = cmd_wr[c] && f == 5;
            ir  = cmd_wr[c] && f == 7;
            rset[c] = rx_raise[c] && !m_ts[c];
            tset[c] = tx_raise[c] && !m_rs[c];
            rclr[c] = rx_clear[c] || (ir && m_rs[c]);
            tclr[c] = txc || (ir && !m_rs[c] && m_ts[c]);
            if (chan_rst[c]) begin
               rset[c] = 0; tset[c] = 0; rclr[c] = 0; tclr[c] = 0;
            end
         end
         for (int c = 0; c < 2; c++) begin
            if (!win && rset[c]) begin nv = code_of(status_hi, c, 0); win = 1; end
            if (!win && tset[c]) begin nv = code_of(status_hi, c, 1); win = 1; end
            if (rclr[c] || tclr[c]) any_clr = 1;
         end
         if (!win && any_clr) nv = code_of(status_hi, 0, 2);
         for (int c = 0; c < 2; c++) begin
            if (chan_rst[c]) begin
               m_rp[c] = 0; m_tp[c] = 0; m_rs[c] = 0; m_ts[c] = 0;
            end else begin
               if (rx_raise[c]) m_rp[c] = 1; else if (rclr[c]) m_rp[c] = 0;
               if (rset[c]) m_rs[c] = 1; else if (rclr[c]) m_rs[c] = 0;
               if (tx_raise[c]) m_tp[c] = 1; else if (tclr[c]) m_tp[c] = 0;
               if (tset[c]) m_ts[c] = 1; else if (tclr[c]) m_ts[c] = 0;
            end
         end
         m_vec = nv;
      end
   end

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (started && !done) begin
         int ep, ei;
         logic [1:0] md [2];
         md[0] = rx_mode_a; md[1] = rx_mode_b;
         ep = (m_rp[0] << 5) | (m_tp[0] << 4) | (m_rp[1] << 2) | (m_tp[1] << 1);
         ei = 0;
         for (int c = 0; c < 2; c++) begin
            if (tx_ien[c] && m_tp[c]) ei = 1;
            if ((md[c] == 2'b01 || md[c] == 2'b10) && m_rp[c]) ei = 1;
            if (brk_ien[c] && brk_status[c]) ei = 1;
         end
         chk(cur_tag, "pend_reg", pend_reg, ep);
         chk(cur_tag, "vector", vector, m_vec);
         chk(cur_tag, "irq", irq, ei);
      end
   end

   task automatic tick(input string t);
      cur_tag = t;
      @(negedge clk); #1;
      chan_rst = '0; rx_raise = '0; rx_clear = '0; tx_raise = '0;
      cmd_wr = '0; cmd_code = '0;
   endtask

   task automatic cmd(input int ch, input logic [7:0] code, input string t);
      cmd_wr[ch] = 1'b1; cmd_code = code; tick(t);
   endtask

   initial begin
      rst_n = 1'b0; chan_rst = '0; rx_raise = '0; rx_clear = '0; tx_raise = '0;
      cmd_wr = '0; cmd_code = '0; tx_ien = '0; rx_mode_a = '0; rx_mode_b = '0;
      brk_ien = '0; brk_status = '0; status_hi = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "irq", irq, 0);
      chk("R1", "pend_reg", pend_reg, 0);
      chk("R1", "vector", vector, 0);
      #1; rst_n = 1'b1; started = 1;
      tick("R1");
      // low encoding, receive A raise
      rx_mode_a = 2'b01; rx_raise[0] = 1; tick("R2 R3 R7");
      tx_raise[0] = 1; tick("R4");              // refused: rx under service
      tx_ien[0] = 1; tick("R7");
      cmd(0, 8'h38, "R6");                      // clears receive A
      cmd(0, 8'h38, "R6");                      // transmit pending but not in service
      cmd(0, 8'h28, "R5");                      // transmit clear
      // high encoding, channel B
      status_hi = 1; tx_raise[1] = 1; tick("R3");
      tx_ien[1] = 1; tick("R7");
      rx_raise[1] = 1; tick("R4");              // refused: tx under service
      cmd(1, 8'h38, "R6");                      // clears transmit B
      rx_raise[1] = 1; tick("R3");
      rx_mode_b = 2'b11; tick("R7");
      rx_mode_b = 2'b10; tick("R7");
      rx_clear[1] = 1; tick("R5");
      tx_raise[0] = 1; tick("R3");
      rx_raise[0] = 1; tick("R4");
      cmd(0, 8'h10, "R11");
      cmd(0, 8'h28, "R5");
      rx_clear[0] = 1; tick("R5");
      // break
      brk_status[0] = 1; tick("R8");
      brk_ien[0] = 1; tick("R8");
      brk_status[0] = 0; brk_ien[0] = 0; tick("R8");
      // same-cycle priority
      rx_raise[1] = 1; tx_raise[0] = 1; tick("R10");
      rx_clear[0] = 1; rx_raise[0] = 1; tick("R10");
      status_hi = 0; rx_clear[1] = 1; cmd_wr[0] = 1; cmd_code = 8'h28; tick("R10");
      rx_raise[0] = 1; rx_raise[1] = 1; tick("R10");
      tx_raise[1] = 1; tick("R2");
      // channel reset A only
      chan_rst[0] = 1; tx_raise[0] = 1; tick("R9");
      chan_rst[1] = 1; tick("R9");
      rx_raise[1] = 1; tick("R9");
      tick("R9");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule